// File: doc/BRIEF.md
# Transfer Counter with Pseudo-DMA Data Window

This block pairs a 24-bit transfer counter with a small data window. The host uses the window to move data into or out of an internal byte buffer without a real DMA engine. The counter is programmed one byte at a time into shadow registers. Those values reach the live counter only when a DMA-mode command strobe arrives. A transfer-information variant of that strobe turns a programmed zero into 65536.

A start request carrying a length arms the window and raises a data-request line. The host then makes byte or halfword accesses through the window:

- Halfwords are big-endian: the high byte sits at the lower buffer index.
- Every access consumes buffer positions.
- Window writes also count the live counter down. When the counter reaches zero, a count-zero flag is raised.
- When the armed length is exhausted, the request line drops and a single-cycle done pulse fires.

A device-side byte port preloads and inspects the buffer. Until the high count byte has been written after reset, reading that byte returns a fixed identification value.

Top module: `pdma_xfer_top`

## Requirements
- R1: After reset, drq_o, done_o and tc_zero_o are 0, the live count is 0, and a read of the high count byte returns CHIP_ID (default 8'hA2).
- R2: reg_sel_i 0, 1, 2 select live count bits 7:0, 15:8, 23:16 on reg_rdata_o, and 3 reads 0. A write with reg_we_i updates only the shadow byte, and the live count does not change.
- R3: dma_cmd_i copies the shadow bytes, as they were before that edge, into the live count. If xfer_cmd_i is also high and the shadow value is zero, the live count becomes 24'h010000 instead.
- R4: The high count byte reads CHIP_ID until the first write to reg_sel_i=2 after reset. From then on it reads live count bits 23:16.
- R5: tc_zero_o is cleared by any count byte write (reg_sel_i 0 to 2) and by dma_cmd_i. It is set when a window write brings the live count to zero. A byte write in the same cycle wins over the set.
- R6: start_i with a nonzero start_len_i raises drq_o on the next edge, sets the remaining length and resets the buffer index to 0. Lengths above DEPTH are clamped to DEPTH. A zero length leaves drq_o low.
- R7: A byte window write (win_half_i=0) stores win_wdata_i[7:0] at the current index. It advances the index by one and decrements both the remaining length and the live count by one.
- R8: A halfword window write stores win_wdata_i[15:8] at the index and win_wdata_i[7:0] at index+1, and decrements both the remaining length and the count by two. With one byte remaining, only the high byte is stored and the step is one. The count saturates at zero.
- R9: A window write while the live count or the remaining length is zero changes neither the buffer, the count, the length nor drq_o.
- R10: During a window read strobe, win_rdata_o is {8'h00, buf[idx]} for a byte read. For a halfword read it is {buf[idx], buf[idx+1]}, with the low byte 0 when only one byte remains. A read advances the index and length but leaves the count unchanged.
- R11: A window read with zero remaining length returns 0 and changes nothing.
- R12: On the edge after an access that drains the remaining length, drq_o falls and done_o is high for exactly one cycle.
- R13: start_i in the same cycle as a window access discards the access. dma_cmd_i in the same cycle as a window write loads the count and discards the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Count byte write strobe |
| reg_sel_i | input | 2 | Count byte select (0 low, 1 middle, 2 high) |
| reg_wdata_i | input | 8 | Count byte write data |
| reg_rdata_o | output | 8 | Count byte readback |
| dma_cmd_i | input | 1 | DMA-mode command strobe, reloads live count |
| xfer_cmd_i | input | 1 | With dma_cmd_i: zero count means 65536 |
| tc_zero_o | output | 1 | Count-zero status |
| start_i | input | 1 | Arm the window |
| start_len_i | input | LW | Armed length in bytes |
| win_wr_i | input | 1 | Window write strobe |
| win_rd_i | input | 1 | Window read strobe |
| win_half_i | input | 1 | Access size: 1 halfword, 0 byte |
| win_wdata_i | input | 16 | Window write data |
| win_rdata_o | output | 16 | Window read data, valid during read strobe |
| drq_o | output | 1 | Data request |
| done_o | output | 1 | One-cycle completion pulse |
| dev_we_i | input | 1 | Device-side buffer write |
| dev_addr_i | input | AW | Device-side buffer index |
| dev_wdata_i | input | 8 | Device-side write byte |
| dev_rdata_o | output | 8 | Buffer byte at dev_addr_i |

## Verification
Two pairs of functions can act on the same edge. The first is a count byte write landing in the cycle where a window write drains the count to zero and the remaining length to zero. The bench drives both strobes together and expects done_o high, drq_o low and tc_zero_o still clear. The second pair is a start or reload coinciding with a window access; there the bench expects the buffer, the count and the length to show only the winning action. Random mixes of strobes, including combined write-and-access cycles, are judged against a bench model that applies the same priority order.

// File: rtl/pdma_xfer_pkg.sv
package pdma_xfer_pkg;
  localparam int unsigned BYTE_W = 8;

  // count decrement request from the window to the counter
  typedef struct packed {
    logic dec;
    logic two;
  } dec_req_t;
endpackage

// File: rtl/xfer_count.sv
module xfer_count
  import pdma_xfer_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned SUB_SHIFT = 16,
  parameter logic [7:0]  CHIP_ID   = 8'hA2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [7:0]       wdata_i,
  input  logic             load_i,
  input  logic             xfer_i,
  input  dec_req_t         dec_i,
  output logic [7:0]       rdata_o,
  output logic [CNT_W-1:0] live_o,
  output logic             tc_zero_o
);
  localparam int unsigned NB      = CNT_W / BYTE_W;
  localparam logic [1:0]  HI_LANE = 2'(NB - 1);
  localparam logic [CNT_W-1:0] ZERO_SUB = CNT_W'(1) << SUB_SHIFT;

  logic [NB-1:0][7:0] shadow_q;
  logic [CNT_W-1:0]   live_q, dec_res, step;
  logic               hi_wr_q, tc_q, any_wr;

  assign any_wr = we_i && (sel_i <= HI_LANE);
  assign step   = dec_i.two ? CNT_W'(2) : CNT_W'(1);
  assign dec_res = (live_q < step) ? '0 : live_q - step;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            shadow_q[g] <= '0;
      else if (we_i && sel_i == 2'(g))        shadow_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q  <= '0;
      hi_wr_q <= 1'b0;
      tc_q    <= 1'b0;
    end else begin
      if (load_i)
        live_q <= (xfer_i && shadow_q == '0) ? ZERO_SUB : shadow_q;
      else if (dec_i.dec)
        live_q <= dec_res;

      if (we_i && sel_i == HI_LANE) hi_wr_q <= 1'b1;

      // byte write beats reload beats set
      if (any_wr)                          tc_q <= 1'b0;
      else if (load_i)                     tc_q <= 1'b0;
      else if (dec_i.dec && dec_res == '0) tc_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NB; i++) begin
      if (sel_i == 2'(i))
        rdata_o = (i == NB - 1 && !hi_wr_q) ? CHIP_ID : live_q[BYTE_W*i +: BYTE_W];
    end
  end

  assign live_o    = live_q;
  assign tc_zero_o = tc_q;
endmodule

// File: rtl/pdma_win.sv
module pdma_win
  import pdma_xfer_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] start_len_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          half_i,
  input  logic [15:0]   wdata_i,
  input  logic          cnt_nz_i,
  output logic [15:0]   rdata_o,
  output dec_req_t      dec_o,
  output logic          drq_o,
  output logic          done_o,
  input  logic          dev_we_i,
  input  logic [AW-1:0] dev_addr_i,
  input  logic [7:0]    dev_wdata_i,
  output logic [7:0]    dev_rdata_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [LW-1:0] rem_q, len_eff, step_l;
  logic [AW-1:0] idx_q, idx1;
  logic          have, ge2, two, acc_wr, acc_rd, last;
  logic          drq_q, done_q;

  assign have    = rem_q != '0;
  assign ge2     = rem_q >= LW'(2);
  assign two     = half_i && ge2;
  assign idx1    = idx_q + AW'(1);
  assign step_l  = two ? LW'(2) : LW'(1);
  assign acc_wr  = wr_i && !start_i && have && cnt_nz_i;
  assign acc_rd  = rd_i && !wr_i && !start_i && have;
  assign last    = (acc_wr || acc_rd) && rem_q == step_l;
  assign len_eff = (start_len_i > LW'(DEPTH)) ? LW'(DEPTH) : start_len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      idx_q  <= '0;
      drq_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (start_i) begin
        rem_q <= len_eff;
        idx_q <= '0;
        drq_q <= len_eff != '0;
      end else if (acc_wr || acc_rd) begin
        rem_q <= rem_q - step_l;
        idx_q <= idx_q + (two ? AW'(2) : AW'(1));
        if (last) drq_q <= 1'b0;
      end
    end
  end

  // window write placed after device write: window wins on a clash
  always_ff @(posedge clk_i) begin
    if (dev_we_i) mem_q[dev_addr_i] <= dev_wdata_i;
    if (acc_wr) begin
      mem_q[idx_q] <= half_i ? wdata_i[15:8] : wdata_i[7:0];
      if (two) mem_q[idx1] <= wdata_i[7:0];
    end
  end

  always_comb begin
    if (!have)       rdata_o = '0;
    else if (half_i) rdata_o = {mem_q[idx_q], ge2 ? mem_q[idx1] : 8'h00};
    else             rdata_o = {8'h00, mem_q[idx_q]};
  end

  assign dec_o.dec   = acc_wr;
  assign dec_o.two   = two;
  assign drq_o       = drq_q;
  assign done_o      = done_q;
  assign dev_rdata_o = mem_q[dev_addr_i];
endmodule

// File: rtl/pdma_xfer_top.sv
module pdma_xfer_top
  import pdma_xfer_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned SUB_SHIFT = 16,
  parameter logic [7:0]  CHIP_ID   = 8'hA2,
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned AW        = $clog2(DEPTH),
  parameter int unsigned LW        = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  input  logic          dma_cmd_i,
  input  logic          xfer_cmd_i,
  output logic          tc_zero_o,
  input  logic          start_i,
  input  logic [LW-1:0] start_len_i,
  input  logic          win_wr_i,
  input  logic          win_rd_i,
  input  logic          win_half_i,
  input  logic [15:0]   win_wdata_i,
  output logic [15:0]   win_rdata_o,
  output logic          drq_o,
  output logic          done_o,
  input  logic          dev_we_i,
  input  logic [AW-1:0] dev_addr_i,
  input  logic [7:0]    dev_wdata_i,
  output logic [7:0]    dev_rdata_o
);
  logic [CNT_W-1:0] cnt_live;
  dec_req_t         dec_req;

  xfer_count #(
    .CNT_W(CNT_W), .SUB_SHIFT(SUB_SHIFT), .CHIP_ID(CHIP_ID)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .load_i    (dma_cmd_i),
    .xfer_i    (xfer_cmd_i),
    .dec_i     (dec_req),
    .rdata_o   (reg_rdata_o),
    .live_o    (cnt_live),
    .tc_zero_o (tc_zero_o)
  );

  pdma_win #(
    .DEPTH(DEPTH), .AW(AW), .LW(LW)
  ) u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_len_i (start_len_i),
    .wr_i        (win_wr_i),
    .rd_i        (win_rd_i),
    .half_i      (win_half_i),
    .wdata_i     (win_wdata_i),
    .cnt_nz_i    (cnt_live != '0),
    .rdata_o     (win_rdata_o),
    .dec_o       (dec_req),
    .drq_o       (drq_o),
    .done_o      (done_o),
    .dev_we_i    (dev_we_i),
    .dev_addr_i  (dev_addr_i),
    .dev_wdata_i (dev_wdata_i),
    .dev_rdata_o (dev_rdata_o)
  );
endmodule

// File: rtl/pdma_xfer_chk.sv
module pdma_xfer_chk #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned LW    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [1:0]       reg_sel_i,
  input logic             dma_cmd_i,
  input logic             start_i,
  input logic [LW-1:0]    start_len_i,
  input logic             drq_o,
  input logic             done_o,
  input logic             tc_zero_o,
  input logic [CNT_W-1:0] cnt_live_i
);
  assert_done_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_drops_drq_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!drq_o && $past(drq_o)));

  assert_tc_cleared_by_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(reg_we_i) && $past(reg_sel_i) != 2'd3) |-> !tc_zero_o);

  // count only grows through a reload (R3, R13)
  assert_count_no_grow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(dma_cmd_i) |-> (cnt_live_i <= $past(cnt_live_i)));

  assert_start_raises_drq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(start_i) && $past(start_len_i) != '0) |-> drq_o);

  assert_start_no_done_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i) |-> !done_o);
endmodule

bind pdma_xfer_top pdma_xfer_chk #(.CNT_W(CNT_W), .LW(LW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .dma_cmd_i   (dma_cmd_i),
  .start_i     (start_i),
  .start_len_i (start_len_i),
  .drq_o       (drq_o),
  .done_o      (done_o),
  .tc_zero_o   (tc_zero_o),
  .cnt_live_i  (cnt_live)
);

// File: tb/pdma_xfer_top_tb_top.sv
module pdma_xfer_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int AW = 5;
  localparam int LW = 6;
  localparam logic [7:0] CHIP_ID = 8'hA2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_we_i, dma_cmd_i, xfer_cmd_i, start_i, win_wr_i, win_rd_i, win_half_i, dev_we_i;
  logic [1:0] reg_sel_i;
  logic [7:0] reg_wdata_i, dev_wdata_i, reg_rdata_o, dev_rdata_o;
  logic [LW-1:0] start_len_i;
  logic [15:0] win_wdata_i, win_rdata_o;
  logic [AW-1:0] dev_addr_i;
  logic tc_zero_o, drq_o, done_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pdma_xfer_top dut_i (.*);

  int n_chk = 0, n_fail = 0;
  logic [23:0] m_shadow, m_live;
  logic m_hiw, m_tc, m_drq, m_done;
  int m_rem, m_idx;
  logic [7:0] m_mem [DEPTH];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic clr();
    reg_we_i = 0; reg_sel_i = 0; reg_wdata_i = 0; dma_cmd_i = 0; xfer_cmd_i = 0;
    start_i = 0; start_len_i = 0; win_wr_i = 0; win_rd_i = 0; win_half_i = 0;
    win_wdata_i = 0; dev_we_i = 0; dev_addr_i = 0; dev_wdata_i = 0;
  endtask

  function automatic logic [15:0] exp_rd(logic half);
    if (m_rem == 0) return 16'h0;
    if (half) return {m_mem[m_idx], (m_rem >= 2) ? m_mem[m_idx+1] : 8'h00};
    return {8'h00, m_mem[m_idx]};
  endfunction

  // reference model of one edge, priorities per R3, R5, R13
  task automatic model_apply();
    logic accw, accr, two;
    int step;
    logic [23:0] nl;
    accw = win_wr_i && !start_i && m_rem != 0 && m_live != 0;
    accr = win_rd_i && !win_wr_i && !start_i && m_rem != 0;
    two  = win_half_i && m_rem >= 2;
    step = two ? 2 : 1;
    m_done = 0;
    if (dev_we_i) m_mem[dev_addr_i] = dev_wdata_i;
    if (start_i) begin
      m_rem = (int'(start_len_i) > DEPTH) ? DEPTH : int'(start_len_i);
      m_idx = 0;
      m_drq = m_rem != 0;
    end else if (accw || accr) begin
      if (accw) begin
        m_mem[m_idx] = win_half_i ? win_wdata_i[15:8] : win_wdata_i[7:0];
        if (two) m_mem[m_idx+1] = win_wdata_i[7:0];
      end
      m_rem -= step;
      m_idx = (m_idx + step) % DEPTH;
      if (m_rem == 0) begin m_drq = 0; m_done = 1; end
    end
    nl = m_live;
    if (dma_cmd_i) nl = (xfer_cmd_i && m_shadow == 0) ? 24'h010000 : m_shadow;
    else if (accw) nl = (m_live < 24'(step)) ? 24'h0 : m_live - 24'(step);
    if (reg_we_i && reg_sel_i != 2'd3) m_tc = 0;
    else if (dma_cmd_i) m_tc = 0;
    else if (accw && nl == 0) m_tc = 1;
    m_live = nl;
    if (reg_we_i && reg_sel_i != 2'd3) begin
      m_shadow[8*reg_sel_i +: 8] = reg_wdata_i;
      if (reg_sel_i == 2'd2) m_hiw = 1;
    end
  endtask

  task automatic check_state(string tag);
    chk(tag, drq_o, m_drq);
    chk(tag, done_o, m_done);
    chk(tag, tc_zero_o, m_tc);
    for (int s = 0; s < 4; s++) begin
      reg_sel_i = 2'(s);
      #1;
      if (s == 3) chk("R2", reg_rdata_o, 0);
      else if (s == 2 && !m_hiw) chk("R4", reg_rdata_o, CHIP_ID);
      else chk((s == 2) ? "R4" : "R2", reg_rdata_o, m_live[8*s +: 8]);
    end
  endtask

  // inputs set just after a rising edge; results checked after the next
  task automatic tick(string tag);
    #2;
    if (win_rd_i && !win_wr_i && !start_i)
      chk((m_rem == 0) ? "R11" : "R10", win_rdata_o, exp_rd(win_half_i));
    model_apply();
    @(posedge clk_i); #1;
    clr();
    check_state(tag);
  endtask

  task automatic wr_cnt(int sel, int val);
    reg_we_i = 1; reg_sel_i = 2'(sel); reg_wdata_i = 8'(val); tick("R2");
  endtask
  task automatic load(logic xf);
    dma_cmd_i = 1; xfer_cmd_i = xf; tick("R3");
  endtask
  task automatic start(int len);
    start_i = 1; start_len_i = LW'(len); tick("R6");
  endtask
  task automatic wwr(logic half, int d, string tag);
    win_wr_i = 1; win_half_i = half; win_wdata_i = 16'(d); tick(tag);
  endtask
  task automatic wrd(logic half, string tag);
    win_rd_i = 1; win_half_i = half; tick(tag);
  endtask
  task automatic chk_buf(string tag, int a);
    dev_addr_i = AW'(a); #1; chk(tag, dev_rdata_o, m_mem[a]); dev_addr_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    report();
  end

  initial begin
    int unsigned sd;
    clr();
    m_shadow = 0; m_live = 0; m_hiw = 0; m_tc = 0; m_drq = 0; m_done = 0;
    m_rem = 0; m_idx = 0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
    sd = $urandom(32'd2024);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(posedge clk_i); #1;
    check_state("R1");

    // R2/R4: shadow only, id until high write
    wr_cnt(0, 8'h34); wr_cnt(1, 8'h12);
    load(0);
    wr_cnt(2, 8'h05);
    load(0);
    // R3: zero substitute
    wr_cnt(0, 0); wr_cnt(1, 0); wr_cnt(2, 0);
    load(1); load(0);

    for (int i = 0; i < DEPTH; i++) begin
      dev_we_i = 1; dev_addr_i = AW'(i); dev_wdata_i = 8'(i * 7 + 3); tick("R7");
    end

    // R9: write with count zero ignored
    start(4);
    wwr(0, 16'h00EE, "R9"); chk_buf("R9", 0);
    wr_cnt(0, 3); load(0);
    wwr(0, 16'h00AB, "R7"); chk_buf("R7", 0);
    wwr(1, 16'h1234, "R8"); chk_buf("R8", 1); chk_buf("R8", 2);
    wwr(0, 16'h0077, "R9"); chk_buf("R9", 3);
    // R5 coincidence: count drains to zero while a count byte is written
    wr_cnt(0, 1); load(0);
    start(1);
    win_wr_i = 1; win_wdata_i = 16'h0055; reg_we_i = 1; reg_sel_i = 2'd1; reg_wdata_i = 0;
    tick("R5");
    chk("R12", done_o, 1);
    // R10/R11 reads
    start(3);
    wrd(0, "R10"); wrd(1, "R10"); wrd(0, "R11");
    start(1); wrd(1, "R10");
    // R8 halfword with one byte left
    wr_cnt(0, 9); load(0);
    start(1); wwr(1, 16'hC3D4, "R8"); chk_buf("R8", 0); chk_buf("R8", 1);
    // R13: start beats access, load beats decrement
    start_i = 1; start_len_i = 2; win_wr_i = 1; win_wdata_i = 16'h00F0; tick("R13");
    chk_buf("R13", 0);
    dma_cmd_i = 1; win_wr_i = 1; win_wdata_i = 16'h0011; tick("R13");
    chk_buf("R13", 0);
    start(40);  // R6 clamp
    start(0);

    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      int r;
      r = $urandom_range(0, 9);
      case (r)
        0: wr_cnt($urandom_range(0, 3), ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 4));
        1: load(1'($urandom_range(0, 1)));
        2: start($urandom_range(0, DEPTH + 3));
        3, 4, 5: wwr(1'($urandom_range(0, 1)), $urandom_range(0, 65535), "R8");
        6, 7: wrd(1'($urandom_range(0, 1)), "R10");
        8: begin
          dev_we_i = 1; dev_addr_i = AW'($urandom_range(0, DEPTH - 1));
          dev_wdata_i = 8'($urandom_range(0, 255)); tick("R7");
        end
        default: begin
          win_wr_i = 1; win_half_i = 1'($urandom_range(0, 1));
          win_wdata_i = 16'($urandom_range(0, 65535));
          reg_we_i = 1; reg_sel_i = 2'($urandom_range(0, 3)); reg_wdata_i = 8'($urandom_range(0, 2));
          dma_cmd_i = 1'($urandom_range(0, 1));
          tick("R5");
        end
      endcase
    end
    for (int i = 0; i < DEPTH; i++) chk_buf("R7", i);
    report();
  end
endmodule